// File: doc/BRIEF.md
# Dual-Bank Byte-Addressed GPIO Controller

This block is a general-purpose I/O peripheral. A host reaches it over an 8-bit register port on a small I/O address space. Each pin has three controls: an enable bit, a direction bit and a level bit. The pins are split into two banks, one in the core power domain and one in the resume power domain. The split index is a parameter. Pins below it belong to the core bank. The remaining pins belong to the resume bank and are renumbered from zero within it.

Both banks share one register layout. The resume bank sits 0x20 above the core bank. Pins are packed eight to a byte, so software reaches a pin by the register kind, the byte `local / 8` and the bit `local % 8`.

On the pad side, each pin has a registered output-enable and a registered output value. Each pin also has an input that passes through a two-flop synchronizer. The level register ignores writes to pins that are set as inputs. Software therefore has to switch a pin to output before its output level can be set.

Top module: `gpio_dual_bank`

## Requirements
- R1: After reset:
  - pins 0..CORE_RST_EN-1 of the core bank and pins 0..RESUME_RST_EN-1 of the resume bank have their enable bit set, and every other enable bit is 0;
  - every direction bit is 1 (input) and every level latch is 0;
  - pad_oe and pad_out are all 0, and bus_rdata is 0.
- R2: Address decoding works as follows:
  - address bit 5 selects the bank (0 = core, 1 = resume, 0x20 higher);
  - bits 4:2 select the register kind: 0 = enable (offset 0x00), 1 = direction (0x04), 2 = level (0x08);
  - bits 1:0 select the byte.
- R3: Pin numbering works as follows:
  - a pin p below RESUME_BASE has local index p in the core bank;
  - any other pin has local index p-RESUME_BASE in the resume bank;
  - its bit sits at byte local/8, bit local%8.
- R4: A read is performed when bus_rd is high at a clock edge. The selected byte appears on bus_rdata after that edge, and bus_rdata is 0 in every cycle that follows an edge without bus_rd.
- R5: Addresses with register kind 3..7 read as 0, and writes to them change nothing.
- R6: A write to an enable or direction byte replaces the bit of every pin that the byte covers, and reads return the written values.
- R7: A write to a level byte updates only the pins whose direction bit is 0. Pins whose direction bit is 1 keep their latched level.
- R8: A level read returns a different source depending on direction:
  - for an output pin (direction 0) it returns the latched level;
  - for an input pin it returns pad_in through two synchronizer flops. A change of pad_in is therefore seen by a read captured at the third clock edge after the change, and not by one captured at the second.
- R9: pad_oe[p] is 1 only when pin p is enabled and its direction bit is 0. pad_out[p] equals the level latch of pin p. Both follow the register state one clock later.
- R10: Bit positions beyond a bank's pin count read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data byte |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data, zero when not reading |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_out | output | NUM_PINS | Pad output values |

## Verification
The bench targets three mistakes:
- **Resume-bank mapping.** A design that mapped resume pins without subtracting the split index would show pad_out toggling on the wrong pin. It would also read back resume bytes that disagree with the bench model after the sweep over all 64 addresses.
- **Level writes to input pins.** A design that let a level write reach an input pin would show a latched level after the pin is turned to output. The bench catches this through pad_out and readback.
- **Synchronizer depth.** A design with a short or missing synchronizer would return the new pad value one read too early.

Beyond these, unmapped register kinds and bits past a bank's pin count must stay zero across writes of all-ones patterns.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
  typedef enum logic [1:0] {
    RK_EN   = 2'd0,
    RK_DIR  = 2'd1,
    RK_LVL  = 2'd2,
    RK_NONE = 2'd3
  } reg_kind_e;

  localparam int unsigned BYTES_PER_KIND = 4;
  localparam int unsigned BANK_ADDR_BIT  = 5;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_dual_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              bank_sel,
  output reg_kind_e         kind,
  output logic [1:0]        byte_idx
);
  logic upper_zero;

  generate
    if (ADDR_W > 6) begin : g_wide
      assign upper_zero = (addr[ADDR_W-1:6] == '0);
    end else begin : g_narrow
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    bank_sel = addr[BANK_ADDR_BIT];
    byte_idx = addr[1:0];
    kind     = RK_NONE;
    if (upper_zero) begin
      unique case (addr[4:2])
        3'd0:    kind = RK_EN;
        3'd1:    kind = RK_DIR;
        3'd2:    kind = RK_LVL;
        default: kind = RK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_dual_pkg::*;
#(
  parameter int unsigned PINS       = 8,
  parameter int unsigned RST_EN_CNT = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  reg_kind_e       kind,
  input  logic [1:0]      byte_idx,
  input  logic [7:0]      wdata,
  output logic [7:0]      rd_byte,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_out
);
  localparam int unsigned PADW = BYTES_PER_KIND * 8;

  function automatic logic [PINS-1:0] rst_en_mask();
    logic [PINS-1:0] m;
    for (int i = 0; i < PINS; i++) m[i] = (i < RST_EN_CNT);
    return m;
  endfunction

  localparam logic [PINS-1:0] RST_EN = rst_en_mask();

  logic [PINS-1:0] en_q, dir_q, lvl_q, oe_q, out_q;
  logic [PINS-1:0] sync_in;
  logic [PINS-1:0] byte_hit, wval;
  logic [PINS-1:0] m_en, m_dir, m_lvl;
  logic [PINS-1:0] lvl_view;
  logic [PADW-1:0] rd_vec;

  gpio_sync2 #(.W(PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (sync_in)
  );

  genvar p;
  generate
    for (p = 0; p < PINS; p++) begin : g_pin
      localparam int unsigned BYI = p / 8;
      localparam int unsigned BTI = p % 8;
      assign byte_hit[p] = wr_en && (byte_idx == 2'(BYI));
      assign wval[p]     = wdata[BTI];
    end
  endgenerate

  assign m_en  = (kind == RK_EN)  ? byte_hit : '0;
  assign m_dir = (kind == RK_DIR) ? byte_hit : '0;
  assign m_lvl = (kind == RK_LVL) ? (byte_hit & ~dir_q) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= RST_EN;
      dir_q <= '1;
      lvl_q <= '0;
      oe_q  <= '0;
      out_q <= '0;
    end else begin
      en_q  <= (en_q  & ~m_en)  | (wval & m_en);
      dir_q <= (dir_q & ~m_dir) | (wval & m_dir);
      lvl_q <= (lvl_q & ~m_lvl) | (wval & m_lvl);
      oe_q  <= en_q & ~dir_q;
      out_q <= lvl_q;
    end
  end

  assign lvl_view = (dir_q & sync_in) | (~dir_q & lvl_q);

  always_comb begin
    unique case (kind)
      RK_EN:   rd_vec = PADW'(en_q);
      RK_DIR:  rd_vec = PADW'(dir_q);
      RK_LVL:  rd_vec = PADW'(lvl_view);
      default: rd_vec = '0;
    endcase
  end

  assign rd_byte = rd_vec[{byte_idx, 3'b000} +: 8];
  assign pad_oe  = oe_q;
  assign pad_out = out_q;

  a_r7_input_level_kept : assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((lvl_q ^ $past(lvl_q)) & $past(dir_q)) == '0));

  a_r7_level_moves_only_on_write : assert property (@(posedge clk) disable iff (rst)
    !(wr_en && kind == RK_LVL) |=> $stable(lvl_q));

  a_r9_oe_needs_enable : assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & ~$past(en_q)) == '0));

  a_r1_dir_reset_input : assert property (@(posedge clk)
    $past(rst) |-> (dir_q == '1 && lvl_q == '0));
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
  import gpio_dual_pkg::*;
#(
  parameter int unsigned NUM_PINS      = 14,
  parameter int unsigned RESUME_BASE   = 10,
  parameter int unsigned CORE_RST_EN   = 7,
  parameter int unsigned RESUME_RST_EN = 3,
  parameter int unsigned ADDR_W        = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [7:0]          bus_wdata,
  input  logic                bus_rd,
  output logic [7:0]          bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out
);
  localparam int unsigned CORE_PINS = RESUME_BASE;
  localparam int unsigned RES_PINS  = NUM_PINS - RESUME_BASE;

  logic       bank_sel;
  reg_kind_e  kind;
  logic [1:0] byte_idx;
  logic       wr_core, wr_res;
  logic [7:0] rd_core, rd_res, rd_sel;
  logic [7:0] rdata_q;

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .bank_sel (bank_sel),
    .kind     (kind),
    .byte_idx (byte_idx)
  );

  assign wr_core = bus_wr && (kind != RK_NONE) && !bank_sel;
  assign wr_res  = bus_wr && (kind != RK_NONE) &&  bank_sel;

  gpio_bank #(.PINS(CORE_PINS), .RST_EN_CNT(CORE_RST_EN)) u_core (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_core),
    .kind     (kind),
    .byte_idx (byte_idx),
    .wdata    (bus_wdata),
    .rd_byte  (rd_core),
    .pad_in   (pad_in[CORE_PINS-1:0]),
    .pad_oe   (pad_oe[CORE_PINS-1:0]),
    .pad_out  (pad_out[CORE_PINS-1:0])
  );

  gpio_bank #(.PINS(RES_PINS), .RST_EN_CNT(RESUME_RST_EN)) u_resume (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_res),
    .kind     (kind),
    .byte_idx (byte_idx),
    .wdata    (bus_wdata),
    .rd_byte  (rd_res),
    .pad_in   (pad_in[NUM_PINS-1:CORE_PINS]),
    .pad_oe   (pad_oe[NUM_PINS-1:CORE_PINS]),
    .pad_out  (pad_out[NUM_PINS-1:CORE_PINS])
  );

  assign rd_sel = (kind == RK_NONE) ? 8'h00 : (bank_sel ? rd_res : rd_core);

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= 8'h00;
    else     rdata_q <= bus_rd ? rd_sel : 8'h00;
  end

  assign bus_rdata = rdata_q;

  a_r4_idle_reads_zero : assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == 8'h00));

  a_r1_outputs_after_reset : assert property (@(posedge clk)
    $past(rst) |-> (bus_rdata == 8'h00 && pad_oe == '0 && pad_out == '0));

  a_r5_unmapped_reads_zero : assert property (@(posedge clk) disable iff (rst)
    (bus_rd && kind == RK_NONE) |=> (bus_rdata == 8'h00));
endmodule

// File: tb/gpio_dual_bank_bench.sv
`timescale 1ns/1ps
module gpio_dual_bank_bench;
  localparam int N  = 14;
  localparam int RB = 10;
  localparam int CE = 7;
  localparam int RE = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [5:0]   addr = '0;
  logic         wr = 1'b0;
  logic         rd = 1'b0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic [N-1:0] pin = '0;
  logic [N-1:0] oe, pout;

  logic [N-1:0] m_en, m_dir, m_lvl;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  gpio_dual_bank #(.NUM_PINS(N), .RESUME_BASE(RB), .CORE_RST_EN(CE),
                   .RESUME_RST_EN(RE), .ADDR_W(6)) u_gpio_dual_bank (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(rdata), .pad_in(pin), .pad_oe(oe), .pad_out(pout)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // pin number addressed by (address, bit), or -1 when nothing is mapped there
  function automatic int pin_of(input logic [5:0] a, input int b);
    int loc;
    loc = int'(a[1:0]) * 8 + b;
    if (a[4:2] > 3'd2) return -1;
    if (!a[5]) return (loc < RB) ? loc : -1;
    return (loc < N - RB) ? RB + loc : -1;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [5:0] a);
    logic [7:0] r;
    r = '0;
    for (int b = 0; b < 8; b++) begin
      int p;
      p = pin_of(a, b);
      if (p >= 0) begin
        case (a[4:2])
          3'd0:    r[b] = m_en[p];
          3'd1:    r[b] = m_dir[p];
          default: r[b] = m_dir[p] ? pin[p] : m_lvl[p];
        endcase
      end
    end
    return r;
  endfunction

  task automatic do_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    for (int b = 0; b < 8; b++) begin
      int p;
      p = pin_of(a, b);
      if (p >= 0) begin
        case (a[4:2])
          3'd0:    m_en[p]  = d[b];
          3'd1:    m_dir[p] = d[b];
          default: if (!m_dir[p]) m_lvl[p] = d[b];
        endcase
      end
    end
  endtask

  task automatic do_rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    d = rdata; rd = 1'b0;
  endtask

  task automatic check_all(input string req);
    logic [7:0] d;
    for (int a = 0; a < 64; a++) begin
      do_rd(6'(a), d);
      chk(req, $sformatf("read addr %0h", a), 32'(d), 32'(exp_byte(6'(a))));
    end
  endtask

  task automatic check_pads(input string req);
    @(negedge clk);
    @(negedge clk);
    chk(req, "pad_oe", 32'(oe), 32'(m_en & ~m_dir));
    chk(req, "pad_out", 32'(pout), 32'(m_lvl));
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    m_en = '0;
    for (int i = 0; i < CE; i++) m_en[i] = 1'b1;
    for (int i = 0; i < RE; i++) m_en[RB + i] = 1'b1;
    m_dir = '1;
    m_lvl = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset values at the ports and in every register
    chk("R1", "rdata after reset", 32'(rdata), 0);
    chk("R1", "pad_oe after reset", 32'(oe), 0);
    check_all("R1");
    check_pads("R1");

    // R2 R3 R5 R6 R10: write a distinct byte to every address, then read all back
    for (int a = 0; a < 64; a++) do_wr(6'(a), 8'((a * 37 + 11) & 255));
    check_all("R6");
    check_pads("R9");
    for (int a = 0; a < 64; a++) do_wr(6'(a), 8'hFF);
    check_all("R10");
    check_pads("R9");

    // R7: level writes reach only output pins
    do_wr(6'h04, 8'h33); do_wr(6'h05, 8'h02); do_wr(6'h24, 8'h05);
    do_wr(6'h08, 8'hFF); do_wr(6'h09, 8'hFF); do_wr(6'h28, 8'hFF);
    check_all("R7");
    check_pads("R7");
    do_wr(6'h08, 8'h00); do_wr(6'h09, 8'h00); do_wr(6'h28, 8'h00);
    check_all("R7");
    check_pads("R7");

    // R3: resume pin 12 is local bit 2 at address 0x28
    do_wr(6'h24, 8'h00);
    do_wr(6'h28, 8'h04);
    check_pads("R3");
    chk("R3", "pad_out pin 12", 32'(pout[12]), 1);
    chk("R3", "pad_out pin 2", 32'(pout[2]), 0);

    // R8: input pins read the synchronized pads
    do_wr(6'h04, 8'hFF); do_wr(6'h05, 8'hFF); do_wr(6'h24, 8'hFF);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      case (k)
        0: pin = 14'h2A5A;
        1: pin = 14'h15A5;
        2: pin = '1;
        default: pin = '0;
      endcase
      repeat (4) @(negedge clk);
      do_rd(6'h08, d); chk("R8", "core level byte 0", 32'(d), 32'(exp_byte(6'h08)));
      do_rd(6'h09, d); chk("R8", "core level byte 1", 32'(d), 32'(exp_byte(6'h09)));
      do_rd(6'h28, d); chk("R8", "resume level byte 0", 32'(d), 32'(exp_byte(6'h28)));
    end

    // R8: two-flop synchronizer latency on pin 0
    @(negedge clk);
    pin[0] = 1'b1;
    do_rd(6'h08, d); chk("R8", "pin0 too early", 32'(d[0]), 0);
    do_rd(6'h08, d); chk("R8", "pin0 after sync", 32'(d[0]), 1);

    // R4: no read means zero data
    @(negedge clk);
    chk("R4", "idle rdata", 32'(rdata), 0);

    finish_run();
  end
endmodule